// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block is the transmit side of a serial port. Software programs an 8-bit mode word through a small register write port. The block then sends one data byte for each valid/ready handshake on its byte input. The mode word picks one of two framings. The first is an asynchronous line frame: a low start bit, 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit, and a high stop bit. The second is a clocked synchronous frame: exactly 8 data bits, with a serial clock driven next to the data.

Bit timing comes from an external baud-tick pulse. In asynchronous mode every bit lasts one tick interval. In synchronous mode every bit lasts two tick intervals. On the first tick the serial clock falls and the new bit is presented; on the second tick the clock rises. A multiprocessor-format input suppresses the parity bit, whatever the parity-enable bit says. The frame format is taken from the mode word and the multiprocessor input as they stand when a byte is accepted. The mode word can be read back at any time. It is locked against writes while a frame is in flight.

Top module: `sertx_top`

## Requirements
- R1: After reset, cfg_rdata reads 0x00, tx_ready is 1, and ser_out and ser_clk are both 1. This also holds when reset is asserted in the middle of a frame.
- R2: A write to the mode word while tx_ready is 1 updates all 8 bits, visible on cfg_rdata in the next cycle. A write while tx_ready is 0 is ignored, and cfg_rdata keeps its value.
- R3: In asynchronous mode (mode bit 7 = 0) the frame sent on ser_out is one 0 start bit, then the data bits LSB first, then one 1 stop bit. The first bit appears on the first baud tick after acceptance, and each later bit appears on the next tick.
- R4: In asynchronous mode, mode bit 6 = 1 sends only data bits 0 to 6, and bit 7 of the byte is never sent. Mode bit 6 = 0 sends all 8 bits.
- R5: In asynchronous mode, mode bit 5 = 1 inserts a parity bit between the last data bit and the stop bit. Mode bit 4 = 0 makes the total number of ones over the sent data bits and the parity bit even. Mode bit 4 = 1 makes that total odd.
- R6: When mp_format is 1 at acceptance, no parity bit is sent, even with mode bit 5 = 1. The stop bit directly follows the data bits.
- R7: In synchronous mode (mode bit 7 = 1) exactly 8 data bits are sent LSB first, whatever mode bits 6 and 5 say, with no start, stop or parity bit. On the first tick of each bit, ser_clk falls and ser_out takes the new bit. On the second tick, ser_clk rises and ser_out holds the bit.
- R8: ser_clk stays 1 whenever the transmitter is idle or is sending an asynchronous frame.
- R9: A byte is accepted on a clock edge where tx_valid and tx_ready are both 1. tx_ready is 0 from the next cycle until the tick that ends the final bit interval: tick N+1 for an N-bit asynchronous frame, and tick 17 in synchronous mode. tx_ready returns to 1 in the cycle after that tick.
- R10: ser_out and ser_clk change only in the cycle after a baud tick, and ser_out is 1 whenever tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 8 | Mode word write value |
| cfg_rdata | output | 8 | Current mode word |
| mp_format | input | 1 | Multiprocessor format active; suppresses parity |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| ser_out | output | 1 | Serial data line, idles high |
| ser_clk | output | 1 | Serial clock for synchronous mode, idles high |

## Verification
The checker watches every cycle for several properties. The lines move only after a baud tick. The lines sit high while the transmitter is idle. The serial clock never pulses during an asynchronous frame. The mode word cannot change while a frame is busy. The ready output drops right after acceptance and comes back only on a tick. In synchronous mode the data stays put across each rising clock edge. The bench scenarios alone can show the content of each frame: the bit order, 7-bit truncation, parity sense, parity suppression by the multiprocessor input, and the exact tick on which the frame ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    // Position of the 4-bit format field inside the mode word
    localparam int MODE_FMT_LSB = 4;
    // Bit positions inside the format field
    localparam int F_SYNC  = 3;
    localparam int F_SEVEN = 2;
    localparam int F_PAR   = 1;
    localparam int F_ODD   = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } tx_state_e;
endpackage

// File: rtl/sertx_modereg.sv
module sertx_modereg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         lock,
    output logic [W-1:0] mode
);
    logic [W-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we && !lock) begin
            mode_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [3:0]         fmt,
    input  logic               mp,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len,
    output logic               sync
);
    int   nd;
    logic par_on;
    logic par;

    always_comb begin
        sync   = fmt[F_SYNC];
        par_on = !fmt[F_SYNC] && fmt[F_PAR] && !mp;
        nd     = fmt[F_SEVEN] ? DATA_W - 1 : DATA_W;
        par    = fmt[F_ODD];
        frame  = '1;
        len    = '0;
        if (sync) begin
            frame[DATA_W-1:0] = data;
            len = CNT_W'(DATA_W);
        end else begin
            frame[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (i < nd) begin
                    frame[i+1] = data[i];
                    par = par ^ data[i];
                end
            end
            if (par_on) begin
                frame[nd+1] = par;
            end
            len = CNT_W'(nd + 2 + (par_on ? 1 : 0));
        end
    end
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   len,
    input  logic               sync,
    input  logic               tick,
    output logic               ready,
    output logic               sdo,
    output logic               sclk
);
    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               sync;
        logic               half;
        logic               sdo;
        logic               sclk;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_BUSY;
                    seq_d.sh   = frame;
                    seq_d.cnt  = len;
                    seq_d.sync = sync;
                    seq_d.half = 1'b0;
                end
            end
            default: begin
                if (tick) begin
                    if (seq_q.sync && seq_q.half) begin
                        seq_d.sclk = 1'b1;
                        seq_d.half = 1'b0;
                    end else if (seq_q.cnt == '0) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.sdo  = 1'b1;
                        seq_d.sclk = 1'b1;
                    end else begin
                        seq_d.sdo = seq_q.sh[0];
                        seq_d.sh  = {1'b1, seq_q.sh[FRAME_W-1:1]};
                        seq_d.cnt = seq_q.cnt - 1'b1;
                        if (seq_q.sync) begin
                            seq_d.sclk = 1'b0;
                            seq_d.half = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.sh   <= '1;
            seq_q.cnt  <= '0;
            seq_q.sync <= 1'b0;
            seq_q.half <= 1'b0;
            seq_q.sdo  <= 1'b1;
            seq_q.sclk <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready = (seq_q.st == ST_IDLE);
    assign sdo   = seq_q.sdo;
    assign sclk  = seq_q.sclk;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    output logic [MODE_W-1:0] cfg_rdata,
    input  logic              mp_format,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              baud_tick,
    output logic              ser_out,
    output logic              ser_clk
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [MODE_W-1:0]  mode;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               sync;
    logic               ready;
    logic               start;

    assign start = tx_valid && ready;

    sertx_modereg #(.W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .lock  (!ready),
        .mode  (mode)
    );

    sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frm (
        .fmt   (mode[MODE_FMT_LSB+3:MODE_FMT_LSB]),
        .mp    (mp_format),
        .data  (tx_data),
        .frame (frame),
        .len   (len),
        .sync  (sync)
    );

    sertx_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .frame (frame),
        .len   (len),
        .sync  (sync),
        .tick  (baud_tick),
        .ready (ready),
        .sdo   (ser_out),
        .sclk  (ser_clk)
    );

    assign cfg_rdata = mode;
    assign tx_ready  = ready;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int MODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [MODE_W-1:0] cfg_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              baud_tick,
    input logic              ser_out,
    input logic              ser_clk
);
    AST_LINES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> ($stable(ser_out) && $stable(ser_clk))); // R10

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (ser_out && ser_clk)); // R10

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !tx_ready) |=> $stable(cfg_rdata)); // R2

    AST_ASYNC_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[MODE_W-1] |-> ser_clk); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R9

    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(baud_tick)); // R9

    AST_SYNC_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[MODE_W-1] && !tx_ready && $rose(ser_clk)) |-> $stable(ser_out)); // R7
endmodule

bind sertx_top sertx_chk #(.MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .baud_tick (baud_tick),
    .ser_out   (ser_out),
    .ser_clk   (ser_clk)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       mp_format = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       baud_tick = 1'b0;
    logic       ser_out;
    logic       ser_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int tcnt = 0;

    always #2 clk = ~clk;

    // one-cycle baud pulse every 5 clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            baud_tick = 1'b0;
        end else begin
            tcnt = (tcnt == 4) ? 0 : tcnt + 1;
            baud_tick = (tcnt == 4);
        end
    end

    sertx_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mp_format (mp_format),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .baud_tick (baud_tick),
        .ser_out   (ser_out),
        .ser_clk   (ser_clk)
    );

    // {mode[7:0], mp, data[7:0]}
    localparam logic [16:0] VEC [8] = '{
        {8'h00, 1'b0, 8'hA5},
        {8'h40, 1'b0, 8'hFF},
        {8'h20, 1'b0, 8'h03},
        {8'h30, 1'b0, 8'h03},
        {8'h60, 1'b0, 8'h81},
        {8'h20, 1'b1, 8'h07},
        {8'h80, 1'b0, 8'h6C},
        {8'hE0, 1'b0, 8'h93}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        tx_valid = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (baud_tick !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] mode, input logic mp, input logic [7:0] d);
        logic [11:0] bits;
        int nd;
        int len;
        logic p;
        cfg_write(mode);
        chk(cfg_rdata, mode, "R2", "mode readback");
        chk({7'd0, tx_ready}, 8'd1, "R9", "ready before send");
        mp_format = mp;
        send(d);
        chk({7'd0, tx_ready}, 8'd0, "R9", "ready after accept");
        chk({7'd0, ser_out}, 8'd1, "R3", "line before first tick");
        if (!mode[7]) begin
            nd = mode[6] ? 7 : 8;
            bits = '1;
            bits[0] = 1'b0;
            p = mode[4];
            for (int i = 0; i < nd; i++) begin
                bits[1+i] = d[i];
                p = p ^ d[i];
            end
            len = nd + 1;
            if (mode[5] && !mp) begin
                bits[len] = p;
                len++;
            end
            bits[len] = 1'b1;
            len++;
            for (int k = 0; k < len; k++) begin
                wait_tick();
                if (k == 0 || k == len - 1)
                    chk({7'd0, ser_out}, {7'd0, bits[k]}, mp ? "R6" : "R3", "start/stop bit");
                else if (k <= nd)
                    chk({7'd0, ser_out}, {7'd0, bits[k]}, mode[6] ? "R4" : "R3", "data bit");
                else
                    chk({7'd0, ser_out}, {7'd0, bits[k]}, "R5", "parity bit");
                chk({7'd0, ser_clk}, 8'd1, "R8", "clock high in async");
                chk({7'd0, tx_ready}, 8'd0, "R9", "ready low in frame");
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                wait_tick();
                chk({7'd0, ser_clk}, 8'd0, "R7", "clock fall");
                chk({7'd0, ser_out}, {7'd0, d[i]}, "R7", "sync data at fall");
                wait_tick();
                chk({7'd0, ser_clk}, 8'd1, "R7", "clock rise");
                chk({7'd0, ser_out}, {7'd0, d[i]}, "R7", "sync data at rise");
                chk({7'd0, tx_ready}, 8'd0, "R9", "ready low in sync frame");
            end
        end
        wait_tick();
        chk({7'd0, tx_ready}, 8'd1, "R9", "ready after end tick");
        chk({7'd0, ser_out}, 8'd1, "R10", "line idle high");
        chk({7'd0, ser_clk}, 8'd1, "R8", "clock idle high");
        mp_format = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_rdata, 8'h00, "R1", "mode after reset");
        chk({7'd0, tx_ready}, 8'd1, "R1", "ready after reset");
        chk({7'd0, ser_out}, 8'd1, "R1", "line after reset");
        chk({7'd0, ser_clk}, 8'd1, "R1", "clock after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            run_frame(VEC[v][16:9], VEC[v][8], VEC[v][7:0]);
        end

        // R2 write during busy is ignored; low bits store when idle
        cfg_write(8'h00);
        send(8'h55);
        wait_tick();
        wait_tick();
        cfg_write(8'hC3);
        chk(cfg_rdata, 8'h00, "R2", "write while busy ignored");
        while (tx_ready !== 1'b1) @(negedge clk);
        chk(cfg_rdata, 8'h00, "R2", "mode after busy frame");
        cfg_write(8'h0F);
        chk(cfg_rdata, 8'h0F, "R2", "low bits readback");

        // R1 reset in the middle of a synchronous frame
        cfg_write(8'h80);
        send(8'hAA);
        wait_tick();
        chk({7'd0, ser_clk}, 8'd0, "R7", "first sync fall");
        rst_n = 1'b0;
        @(negedge clk);
        chk(cfg_rdata, 8'h00, "R1", "mode after mid-frame reset");
        chk({7'd0, tx_ready}, 8'd1, "R1", "ready after mid-frame reset");
        chk({7'd0, ser_out}, 8'd1, "R1", "line after mid-frame reset");
        chk({7'd0, ser_clk}, 8'd1, "R1", "clock after mid-frame reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(8'h00, 1'b0, 8'h3C);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule